// File: doc/BRIEF.md
# Memory-Sequenced Timing Strobe Generator

This block derives eight timing strobes from a stored pattern instead of from decode logic. A master clock nominally at 640 kHz is halved, and the halved rate steps a 13-bit address. The low 12 bits of the address come from a binary counter. The top bit comes from a toggle stage that flips each time the low counter wraps. The pattern word at the current address is registered on every master clock, and the registered word is the strobe output.

Bit 7 of the registered word marks the end of the pattern. When it is high, the address and the divider return to zero, so the pattern repeats forever with no outside trigger. After a reset, a power-on hold keeps the sequencer at address zero for `POR_CYCLES` master clocks. The default of 640000 cycles is one second. Sequencing starts when the hold ends.

The pattern is computed from the address inside the module. The encoding below is fixed by the requirements.
- Bit 0 is the sample strobe.
- Bit 1 marks address 0.
- Bit 2 is address bit 12.
- Bits 6:3 are address bits 3:0.
- Bit 7 is the end marker, set only at `END_ADDR`.

The defaults give 6400 addresses per sweep and eight samples per sweep, which is 400 samples per second.

Top module: `rom_strobe_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `strobe` = 0 and `seq_start` = 0.
- R2: After `rst` falls, the sequencer holds address 0 for `POR_CYCLES` rising edges. During that hold, `strobe` shows the address-0 word (after the first edge) and `seq_start` stays low.
- R3: Each address is presented for two master clocks. Address bits 3:0 appear on `strobe[6:3]`.
- R4: `strobe` equals the pattern word of the address held in the previous master clock cycle. The pattern is defined as follows:
  - bit0 = sample strobe
  - bit1 = (address == 0)
  - bit2 = address bit 12
  - bits6:3 = address[3:0]
  - bit7 = (address == `END_ADDR`)
- R5: Address bit 12 is a toggle stage that flips when the low 12-bit counter wraps from 4095 to 0. `strobe[2]` is high exactly for addresses 4096 and above.
- R6: `strobe[7]` is high for two consecutive cycles at the end of each sequence. The next sequence then begins, and a full sequence lasts 2·`END_ADDR`+3 master clocks.
- R7: `seq_start` is a one-cycle pulse in the first cycle of each sequence, when the address is 0 and the divider phase is 0.
- R8: `strobe[0]` is high for addresses that are multiples of `SAMPLE_GAP` and below 8·`SAMPLE_GAP`. This gives eight samples per sequence.
- R9: `strobe[1]` is high only while the address-0 word is registered.
- R10: Raising `rst` in the middle of a sequence abandons it. A full power-on hold follows before the next sequence begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; starts the power-on hold |
| strobe | output | 8 | Registered pattern word (timing strobes) |
| seq_start | output | 1 | One-cycle pulse at the start of each sequence |

## Verification
The strobe word lags its address by one master clock. The address changes only every second clock, so a sequence position p (counted from the `seq_start` cycle) shows the word of address max(p−1,0)/2, and the pattern period is 2·`END_ADDR`+3 cycles. The first `seq_start` is due exactly `POR_CYCLES` edges after the first edge with `rst` low. The bench keeps a cycle counter from that edge and derives the expected word and pulse for every cycle. It compares them at the falling edge, after the registers have settled. Runs cover several full sequences, including the upper half of the address space, and a reset applied mid-sequence.

// File: rtl/rom_strobe_seq.sv
module rom_strobe_seq #(
  parameter int ADDR_W     = 13,
  parameter int END_ADDR   = 6399,
  parameter int SAMPLE_GAP = 800,
  parameter int POR_CYCLES = 640000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] strobe,
  output logic       seq_start
);
  localparam int LOW_W = ADDR_W - 1;
  localparam int POR_W = $clog2(POR_CYCLES + 1);

  logic [POR_W-1:0]  por_cnt;
  logic              hold;
  logic              half;
  logic [LOW_W-1:0]  lo;
  logic              hi;
  logic              rst_seen;
  logic [ADDR_W-1:0] addr;
  logic              seq_rst;

  assign addr      = {hi, lo};
  assign seq_rst   = hold | strobe[7];
  assign seq_start = rst_seen & ~seq_rst;

  function automatic logic [7:0] pattern(input logic [ADDR_W-1:0] a);
    logic [31:0] ai;
    logic [7:0]  w;
    ai   = {{(32-ADDR_W){1'b0}}, a};
    w[0] = (ai < 32'(8*SAMPLE_GAP)) && (ai % 32'(SAMPLE_GAP) == 32'd0);
    w[1] = (ai == 32'd0);
    w[2] = a[ADDR_W-1];
    w[6:3] = a[3:0];
    w[7] = (ai == 32'(END_ADDR));
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      por_cnt <= '0;
      hold    <= 1'b1;
    end else if (hold) begin
      por_cnt <= por_cnt + 1'b1;
      if (por_cnt == POR_W'(POR_CYCLES - 1)) hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || seq_rst) begin
      half <= 1'b0;
      lo   <= '0;
      hi   <= 1'b0;
    end else begin
      half <= ~half;
      if (half) begin
        lo <= lo + 1'b1;
        if (&lo) hi <= ~hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe   <= '0;
      rst_seen <= 1'b1;
    end else begin
      strobe   <= pattern(addr);
      rst_seen <= seq_rst;
    end
  end

  a_r2_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
    hold |-> (addr == '0 && !half));

  a_r3_address_held: assert property (@(posedge clk) disable iff (rst)
    (!seq_rst && !half) |=> (addr == $past(addr)));

  a_r5_upper_toggle: assert property (@(posedge clk) disable iff (rst)
    (!seq_rst && half && (&lo)) |=> (hi != $past(hi)));

  a_r6_end_restart: assert property (@(posedge clk) disable iff (rst)
    strobe[7] |=> (addr == '0 && !half));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);

  a_r7_pulse_origin: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (addr == '0 && !half && !hold));
endmodule

// File: tb/rom_strobe_seq_tb.sv
`timescale 1ns/1ps
module rom_strobe_seq_tb;
  localparam int END_A = 6399;
  localparam int GAP   = 800;
  localparam int POR   = 16;
  localparam int PER   = 2*END_A + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] strobe;
  logic seq_start;

  int checks = 0;
  int failures = 0;
  int k = 0;
  int cyc = 0;
  bit chk_en = 1'b0;
  bit second = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rom_strobe_seq #(.ADDR_W(13), .END_ADDR(END_A), .SAMPLE_GAP(GAP), .POR_CYCLES(POR)) u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .seq_start(seq_start));

  function automatic logic [7:0] expect_word(input int a);
    logic [7:0] w;
    w[0] = (a < 8*GAP) && (a % GAP == 0);
    w[1] = (a == 0);
    w[2] = (a >= 4096);
    w[6:3] = 4'(a % 16);
    w[7] = (a == END_A);
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_en && !done) begin
      if (rst) begin
        k = 0;
        check("R1 strobe", int'(strobe), 0);
        check("R1 seq_start", int'(seq_start), 0);
      end else begin
        k++;
        if (k < POR) begin
          if (second) begin
            check("R10 hold strobe", int'(strobe), int'(expect_word(0)));
            check("R10 hold seq_start", int'(seq_start), 0);
          end else begin
            check("R2 hold strobe", int'(strobe), int'(expect_word(0)));
            check("R2 hold seq_start", int'(seq_start), 0);
          end
        end else begin
          int p, a;
          logic [7:0] e;
          p = (k - POR) % PER;
          a = (p == 0) ? 0 : (p - 1) / 2;
          e = expect_word(a);
          check("R4 word", int'(strobe), int'(e));
          check("R8 sample bit", int'(strobe[0]), int'(e[0]));
          check("R9 origin bit", int'(strobe[1]), int'(e[1]));
          check("R5 upper bit", int'(strobe[2]), int'(e[2]));
          check("R3 low nibble", int'(strobe[6:3]), int'(e[6:3]));
          check("R6 end bit", int'(strobe[7]), int'(e[7]));
          check(second ? "R10 seq_start" : "R7 seq_start", int'(seq_start), int'(p == 0));
        end
      end
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    wait_cycles(2);
    chk_en = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(POR + 3*PER + 100);
    rst = 1'b1;
    second = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(POR + PER + 50);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule